// File: doc/BRIEF.md
# Transceiver Soft-Configuration Recovery Sequencer

This controller finishes bringing up a serial-link transceiver whose basic settings are burned into fuses. It assumes the master link and the control-channel port are already running from those fused settings. It waits for a start command and issues no bus traffic before that. It then runs a fixed recipe over a simple register master port. The recipe is:

- Switch off the transceiver's watchdog and startup timeout.
- Load the remaining configuration from an internal computed image that never touches fused addresses.
- Pulse the e-port phase-aligner reset.
- Pulse the phase-shifter PLL reset and each DLL reset in turn, with a lock wait after each release.
- Switch the timeout and watchdog back on.

Once the recipe completes, the block sits in a monitoring phase. In this phase it periodically reads one register of the loaded image whose configured value is non-zero. A zero read means the soft configuration was silently lost. The recipe then re-runs from the watchdog-disable write, not from power-up, and a saturating counter records each completed recovery. A one-cycle pulse tells downstream logic that it may now set up its peripheral controller. A parameter moves this pulse to the moment the start command is taken, because that setup is also allowed before the watchdog-disable step.

Every bus transaction holds its strobe until the target answers with ready. A transaction that waits too long sets an error flag and returns the controller to idle.

Top module: `xcvr_recovery_seq`

## Requirements
- R1: After reset, busy, done and error are 0 and neither bus strobe is active until start is asserted.
- R2: The first write of every run goes to CTRL_ADDR with data 0x00. In that register, bit 0 is the watchdog enable and bit 1 is the startup-timeout enable.
- R3: Next come CFG_WORDS writes in ascending order: entry i goes to address CFG_BASE+i with data CFG_SEED XOR i. No write of the block ever targets an address in the fused range FUSE_LO..FUSE_HI.
- R4: The phase-aligner reset is written 1 and then 0 at PA_RST_ADDR. With a zero-latency target, exactly PULSE_W+1 cycles without a strobe separate the two writes.
- R5: The PLL reset (PLL_RST_ADDR), then DLL d (DLL_RST_BASE+d) for d in ascending order, is each written 1, then PULSE_W+1 idle cycles, then 0. Each release is followed by exactly LOCK_W+1 idle cycles before the next strobe.
- R6: Only after all resets does the block write 0x03 to CTRL_ADDR. It then drops busy and raises done. Busy and done are never high together.
- R7: While done, the block reads CFG_BASE. The first read comes POLL_W+1 idle cycles after the final write, and later reads come POLL_W idle cycles apart.
- R8: A poll read returning 0 drops done and restarts the recipe at the CTRL_ADDR 0x00 write. Each recovery run that completes adds 1 to recov_cnt, which saturates at 255.
- R9: periph_go is a one-cycle pulse. With the default setting it fires once when a start-commanded run completes and never for recovery runs.
- R10: If a strobe waits TIMEOUT cycles without ready, the strobe drops, error goes to 1, and busy and done go to 0. The next accepted start clears error.
- R11: A start asserted while busy has no effect on the running sequence.
- R12: While the target holds ready low, the strobe stays asserted with stable address and data. Read and write strobes are never both active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the recipe (taken in idle or between polls) |
| bus_addr | output | AW | Register address |
| bus_wdata | output | DW | Write data |
| bus_wr | output | 1 | Write strobe, held until ready |
| bus_rd | output | 1 | Read strobe, held until ready |
| bus_ready | input | 1 | Target accepts the current transaction |
| bus_rdata | input | DW | Read data, valid with ready |
| busy | output | 1 | Recipe in progress |
| done | output | 1 | Recipe complete, monitoring |
| error | output | 1 | A transaction timed out |
| periph_go | output | 1 | One-cycle permit for peripheral-controller setup |
| recov_cnt | output | CNT_W | Saturating count of completed recoveries |

## Verification
On every cycle, the assertions check these properties:
- Strobes stay exclusive.
- Address and data hold while the target stalls.
- Writes keep out of the fused range.
- Polls target only the watched register.
- Busy and done stay exclusive.
- Error keeps the block idle.
- The permit pulse lasts one cycle.
- The recovery counter only steps up by one.

Only the bench scenarios can show the following:
- The full ordering of the recipe and its data values.
- The exact idle gaps for reset pulses, lock waits and poll spacing.
- A restart triggered by a zeroed watched register.
- Counter saturation after hundreds of recoveries.
- Timeout recovery through a new start.
- A start being ignored mid-run.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
   typedef enum logic [1:0] {
      OP_WR    = 2'd0,
      OP_PULSE = 2'd1,
      OP_LOCK  = 2'd2,
      OP_END   = 2'd3
   } op_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_EXEC  = 3'd1,
      ST_WAIT  = 3'd2,
      ST_MWAIT = 3'd3,
      ST_MRD   = 3'd4
   } seq_state_e;
endpackage

// File: rtl/xrs_step_rom.sv
module xrs_step_rom
   import xrs_pkg::*;
#(
   parameter int AW           = 8,
   parameter int DW           = 8,
   parameter int PW           = 6,
   parameter int CFG_WORDS    = 16,
   parameter int NUM_DLL      = 4,
   parameter int CTRL_ADDR    = 0,
   parameter int PA_RST_ADDR  = 1,
   parameter int PLL_RST_ADDR = 2,
   parameter int DLL_RST_BASE = 3,
   parameter int CFG_BASE     = 64,
   parameter int CFG_SEED     = 165,
   parameter int CTRL_ON      = 3
) (
   input  logic [PW-1:0] idx,
   output op_kind_e      kind,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] data
);
   localparam int RST_FIRST = CFG_WORDS + 4;
   localparam int RST_LAST  = RST_FIRST + 4 * (NUM_DLL + 1);

   always_comb begin
      int j;
      int k;
      int unit_addr;
      j         = int'(idx);
      k         = 0;
      unit_addr = 0;
      kind      = OP_END;
      addr      = '0;
      data      = '0;
      if (j == 0) begin
         kind = OP_WR;
         addr = AW'(CTRL_ADDR);
         data = '0;
      end else if (j <= CFG_WORDS) begin
         kind = OP_WR;
         addr = AW'(CFG_BASE + j - 1);
         data = DW'(CFG_SEED ^ (j - 1));
      end else if (j == CFG_WORDS + 1) begin
         kind = OP_WR;
         addr = AW'(PA_RST_ADDR);
         data = DW'(1);
      end else if (j == CFG_WORDS + 2) begin
         kind = OP_PULSE;
      end else if (j == CFG_WORDS + 3) begin
         kind = OP_WR;
         addr = AW'(PA_RST_ADDR);
         data = '0;
      end else if (j < RST_LAST) begin
         k         = j - RST_FIRST;
         unit_addr = (k / 4 == 0) ? PLL_RST_ADDR : DLL_RST_BASE + k / 4 - 1;
         case (k % 4)
            0: begin kind = OP_WR; addr = AW'(unit_addr); data = DW'(1); end
            1: kind = OP_PULSE;
            2: begin kind = OP_WR; addr = AW'(unit_addr); data = '0; end
            default: kind = OP_LOCK;
         endcase
      end else if (j == RST_LAST) begin
         kind = OP_WR;
         addr = AW'(CTRL_ADDR);
         data = DW'(CTRL_ON);
      end
   end
endmodule

// File: rtl/xrs_timer.sv
module xrs_timer #(
   parameter int TW = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          zero
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/xrs_bus_port.sv
module xrs_bus_port #(
   parameter int AW      = 8,
   parameter int DW      = 8,
   parameter int TIMEOUT = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_wr,
   input  logic          req_rd,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          bus_ready,
   output logic          bus_wr,
   output logic          bus_rd,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   output logic          accept,
   output logic          timed_out
);
   localparam int TCW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

   logic stalled;

   assign bus_wr    = req_wr;
   assign bus_rd    = req_rd;
   assign bus_addr  = req_addr;
   assign bus_wdata = req_wdata;
   assign accept    = (req_wr | req_rd) & bus_ready;
   assign stalled   = (req_wr | req_rd) & ~bus_ready;

   generate
      if (TIMEOUT == 0) begin : g_no_timeout
         assign timed_out = 1'b0;
      end else begin : g_timeout
         logic [TCW-1:0] wait_q;
         assign timed_out = stalled && (wait_q == TCW'(TIMEOUT - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          wait_q <= '0;
            else if (!stalled)   wait_q <= '0;
            else if (!timed_out) wait_q <= wait_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/xcvr_recovery_seq.sv
module xcvr_recovery_seq
   import xrs_pkg::*;
#(
   parameter int AW           = 8,
   parameter int DW           = 8,
   parameter int CFG_WORDS    = 16,
   parameter int NUM_DLL      = 4,
   parameter int CTRL_ADDR    = 0,
   parameter int PA_RST_ADDR  = 1,
   parameter int PLL_RST_ADDR = 2,
   parameter int DLL_RST_BASE = 3,
   parameter int FUSE_LO      = 16,
   parameter int FUSE_HI      = 63,
   parameter int CFG_BASE     = 64,
   parameter int CFG_SEED     = 165,
   parameter int PULSE_W      = 16,
   parameter int LOCK_W       = 4096,
   parameter int POLL_W       = 65536,
   parameter int TIMEOUT      = 256,
   parameter int EARLY_PERIPH = 0,
   parameter int CNT_W        = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic [AW-1:0]    bus_addr,
   output logic [DW-1:0]    bus_wdata,
   output logic             bus_wr,
   output logic             bus_rd,
   input  logic             bus_ready,
   input  logic [DW-1:0]    bus_rdata,
   output logic             busy,
   output logic             done,
   output logic             error,
   output logic             periph_go,
   output logic [CNT_W-1:0] recov_cnt
);
   localparam int NSTEPS  = CFG_WORDS + 4 + 4 * (NUM_DLL + 1) + 2;
   localparam int PW      = $clog2(NSTEPS);
   localparam int WMAX_A  = (PULSE_W > LOCK_W) ? PULSE_W : LOCK_W;
   localparam int WMAX    = (WMAX_A > POLL_W) ? WMAX_A : POLL_W;
   localparam int TW      = $clog2(WMAX + 1);
   localparam int CTRL_ON = 3;

   generate
      if (DW < 2)                                     begin : g_chk_dw   $error("DW must be at least 2"); end
      if (PULSE_W < 1 || LOCK_W < 1 || POLL_W < 1)    begin : g_chk_wait $error("wait lengths must be at least 1"); end
      if (TIMEOUT == 1)                               begin : g_chk_to   $error("TIMEOUT must be 0 or at least 2"); end
      if (CFG_WORDS < 1)                              begin : g_chk_cw   $error("CFG_WORDS must be at least 1"); end
      if (CFG_BASE + CFG_WORDS > (1 << AW))           begin : g_chk_cfg  $error("config image exceeds address space"); end
      if (!(CFG_BASE > FUSE_HI || CFG_BASE + CFG_WORDS - 1 < FUSE_LO))
                                                      begin : g_chk_fuse $error("config image overlaps fused range"); end
      if (DLL_RST_BASE + NUM_DLL - 1 >= FUSE_LO && DLL_RST_BASE <= FUSE_HI)
                                                      begin : g_chk_dll  $error("reset registers overlap fused range"); end
      if ((CFG_SEED % (1 << DW)) == 0)                begin : g_chk_seed $error("watched register value must be non-zero"); end
      if (CNT_W < 1)                                  begin : g_chk_cnt  $error("CNT_W must be at least 1"); end
   endgenerate

   seq_state_e       state_q;
   logic [PW-1:0]    ptr_q;
   logic             recov_q;
   logic             err_q;
   logic             pgo_q;
   logic [CNT_W-1:0] rcnt_q;

   op_kind_e         kind;
   logic [AW-1:0]    rom_addr;
   logic [DW-1:0]    rom_data;
   logic             req_wr, req_rd;
   logic [AW-1:0]    req_addr;
   logic             accept, timed_out;
   logic             t_load, t_zero;
   logic [TW-1:0]    t_val;
   logic             start_ok;
   logic             ev_start, ev_first_done, pgo_ev;

   xrs_step_rom #(
      .AW(AW), .DW(DW), .PW(PW), .CFG_WORDS(CFG_WORDS), .NUM_DLL(NUM_DLL),
      .CTRL_ADDR(CTRL_ADDR), .PA_RST_ADDR(PA_RST_ADDR), .PLL_RST_ADDR(PLL_RST_ADDR),
      .DLL_RST_BASE(DLL_RST_BASE), .CFG_BASE(CFG_BASE), .CFG_SEED(CFG_SEED),
      .CTRL_ON(CTRL_ON)
   ) u_rom (
      .idx(ptr_q), .kind(kind), .addr(rom_addr), .data(rom_data)
   );

   assign req_wr   = (state_q == ST_EXEC) && (kind == OP_WR);
   assign req_rd   = (state_q == ST_MRD);
   assign req_addr = req_rd ? AW'(CFG_BASE) : rom_addr;

   xrs_bus_port #(.AW(AW), .DW(DW), .TIMEOUT(TIMEOUT)) u_bus (
      .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
      .req_addr(req_addr), .req_wdata(rom_data), .bus_ready(bus_ready),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .accept(accept), .timed_out(timed_out)
   );

   always_comb begin
      t_load = 1'b0;
      t_val  = '0;
      if (state_q == ST_EXEC) begin
         case (kind)
            OP_PULSE: begin t_load = 1'b1; t_val = TW'(PULSE_W - 1); end
            OP_LOCK:  begin t_load = 1'b1; t_val = TW'(LOCK_W - 1);  end
            OP_END:   begin t_load = 1'b1; t_val = TW'(POLL_W - 1);  end
            default:  ;
         endcase
      end else if (state_q == ST_MRD && accept && bus_rdata != '0) begin
         t_load = 1'b1;
         t_val  = TW'(POLL_W - 1);
      end
   end

   xrs_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
   );

   assign start_ok      = start && (state_q == ST_IDLE || state_q == ST_MWAIT);
   assign ev_start      = start_ok;
   assign ev_first_done = !start_ok && (state_q == ST_EXEC) && (kind == OP_END) && !recov_q;

   generate
      if (EARLY_PERIPH != 0) begin : g_pgo_early
         assign pgo_ev = ev_start;
      end else begin : g_pgo_late
         assign pgo_ev = ev_first_done;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ptr_q   <= '0;
         recov_q <= 1'b0;
         err_q   <= 1'b0;
         pgo_q   <= 1'b0;
         rcnt_q  <= '0;
      end else begin
         pgo_q <= pgo_ev;
         if (start_ok) begin
            state_q <= ST_EXEC;
            ptr_q   <= '0;
            recov_q <= 1'b0;
            err_q   <= 1'b0;
         end else begin
            case (state_q)
               ST_EXEC: begin
                  case (kind)
                     OP_WR: begin
                        if (timed_out) begin
                           state_q <= ST_IDLE;
                           err_q   <= 1'b1;
                        end else if (accept) begin
                           ptr_q <= ptr_q + 1'b1;
                        end
                     end
                     OP_PULSE, OP_LOCK: state_q <= ST_WAIT;
                     default: begin
                        state_q <= ST_MWAIT;
                        recov_q <= 1'b0;
                        if (recov_q && rcnt_q != '1) rcnt_q <= rcnt_q + 1'b1;
                     end
                  endcase
               end
               ST_WAIT: begin
                  if (t_zero) begin
                     ptr_q   <= ptr_q + 1'b1;
                     state_q <= ST_EXEC;
                  end
               end
               ST_MWAIT: begin
                  if (t_zero) state_q <= ST_MRD;
               end
               ST_MRD: begin
                  if (timed_out) begin
                     state_q <= ST_IDLE;
                     err_q   <= 1'b1;
                  end else if (accept) begin
                     if (bus_rdata == '0) begin
                        state_q <= ST_EXEC;
                        ptr_q   <= '0;
                        recov_q <= 1'b1;
                     end else begin
                        state_q <= ST_MWAIT;
                     end
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign busy      = (state_q == ST_EXEC) || (state_q == ST_WAIT);
   assign done      = (state_q == ST_MWAIT) || (state_q == ST_MRD);
   assign error     = err_q;
   assign periph_go = pgo_q;
   assign recov_cnt = rcnt_q;
endmodule

// File: rtl/xrs_checker.sv
module xrs_checker #(
   parameter int AW       = 8,
   parameter int DW       = 8,
   parameter int FUSE_LO  = 16,
   parameter int FUSE_HI  = 63,
   parameter int CFG_BASE = 64,
   parameter int CNT_W    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [AW-1:0]    bus_addr,
   input logic [DW-1:0]    bus_wdata,
   input logic             bus_wr,
   input logic             bus_rd,
   input logic             bus_ready,
   input logic             busy,
   input logic             done,
   input logic             error,
   input logic             periph_go,
   input logic [CNT_W-1:0] recov_cnt
);
   assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !done) |-> (!bus_wr && !bus_rd));

   assert_fuse_untouched_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> (int'(bus_addr) < FUSE_LO || int'(bus_addr) > FUSE_HI));

   assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   assert_poll_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |-> (int'(bus_addr) == CFG_BASE));

   assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (recov_cnt != $past(recov_cnt)) |-> (recov_cnt == CNT_W'($past(recov_cnt) + 1'b1)));

   assert_permit_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      periph_go |=> !periph_go);

   assert_error_parks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> (!busy && !done));

   assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));

   assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && $past(bus_wr && !bus_ready)) |-> ($stable(bus_addr) && $stable(bus_wdata)));
endmodule

bind xcvr_recovery_seq xrs_checker #(
   .AW(AW), .DW(DW), .FUSE_LO(FUSE_LO), .FUSE_HI(FUSE_HI),
   .CFG_BASE(CFG_BASE), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ready(bus_ready), .busy(busy),
   .done(done), .error(error), .periph_go(periph_go), .recov_cnt(recov_cnt)
);

// File: tb/tb_xcvr_recovery_seq.sv
`timescale 1ns/1ps
module tb_xcvr_recovery_seq;
   localparam int P_PULSE = 3;
   localparam int P_LOCK  = 6;
   localparam int P_POLL  = 10;
   localparam int P_TO    = 8;
   localparam int NWR     = 14;

   // {addr, data, idle gap before strobe}; gap 8'hFF is not checked
   localparam logic [23:0] EXP_WR [NWR] = '{
      24'h00_00_FF, 24'h40_A5_00, 24'h41_A4_00, 24'h42_A7_00, 24'h43_A6_00,
      24'h01_01_00, 24'h01_00_04, 24'h02_01_00, 24'h02_00_04,
      24'h03_01_07, 24'h03_00_04, 24'h04_01_07, 24'h04_00_04, 24'h00_03_07
   };

   logic       clk = 0;
   logic       rst_n = 0;
   logic       start = 0;
   logic [7:0] bus_addr, bus_wdata, bus_rdata;
   logic       bus_wr, bus_rd;
   logic       bus_ready = 0;
   logic       busy, done, error, periph_go;
   logic [7:0] recov_cnt;

   logic [7:0] mem [256];
   int n_tests = 0, n_fail = 0;
   int lat = 0, hold = 0, idle = 0;
   bit dead = 0, lose = 0, done_q = 0;
   int wcount = 0, rcount = 0, raddr = 0, rgap = 0, pcount = 0, drises = 0;
   int wa [32], wd [32], wg [32];

   always #10 clk = ~clk;

   assign bus_rdata = mem[bus_addr];

   xcvr_recovery_seq #(
      .CFG_WORDS(4), .NUM_DLL(2), .PULSE_W(P_PULSE), .LOCK_W(P_LOCK),
      .POLL_W(P_POLL), .TIMEOUT(P_TO)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_ready(bus_ready), .bus_rdata(bus_rdata), .busy(busy), .done(done),
      .error(error), .periph_go(periph_go), .recov_cnt(recov_cnt)
   );

   // target model and traffic log, evaluated away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         bus_ready = 0; hold = 0; idle = 0;
      end else begin
         if (bus_wr || bus_rd) begin
            bus_ready = !dead && (hold >= lat);
            hold++;
            if (bus_ready) begin
               if (bus_wr) begin
                  if (wcount < 32) begin
                     wa[wcount] = bus_addr; wd[wcount] = bus_wdata; wg[wcount] = idle;
                  end
                  wcount++;
                  if (!(lose && bus_addr == 8'h40)) mem[bus_addr] = bus_wdata;
               end else begin
                  rcount++; raddr = bus_addr; rgap = idle;
               end
               idle = 0; hold = 0;
            end
         end else begin
            bus_ready = 0; hold = 0; idle++;
         end
         if (periph_go) pcount++;
         if (done && !done_q) drises++;
         done_q = done;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic do_start();
      start = 1;
      for (int i = 0; i < 40 && !busy; i++) tick();
      start = 0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 3000 && !done; i++) tick();
   endtask

   task automatic clear_log();
      @(posedge clk); #1;
      wcount = 0; rcount = 0;
   endtask

   task automatic check_table(input string tag, input bit gaps);
      chk(wcount == NWR, {tag, " write count"}, wcount, NWR);
      for (int i = 0; i < NWR; i++) begin
         chk(wa[i] == int'(EXP_WR[i][23:16]), {tag, " write address"}, wa[i], EXP_WR[i][23:16]);
         chk(wd[i] == int'(EXP_WR[i][15:8]),  {tag, " write data"},    wd[i], EXP_WR[i][15:8]);
         if (gaps && EXP_WR[i][7:0] != 8'hFF)
            chk(wg[i] == int'(EXP_WR[i][7:0]), {tag, " idle gap"}, wg[i], EXP_WR[i][7:0]);
      end
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = (i >= 16 && i <= 63) ? 8'h5C : 8'h00;
      mem[0] = 8'h03;
      repeat (3) tick();
      rst_n = 1;

      // R1: idle after reset, no strobes before start
      begin
         int strobes = 0;
         for (int i = 0; i < 20; i++) begin tick(); if (bus_wr || bus_rd) strobes++; end
         chk(strobes == 0, "R1 strobes before start", strobes, 0);
         chk({busy, done, error} == 3'b000, "R1 status after reset", {busy, done, error}, 0);
      end

      // R2..R6: full recipe with zero-latency target
      do_start();
      wait_done();
      check_table("R2 R3 R4 R5 R6 first run", 1);
      chk(done && !busy, "R6 done after final write", {busy, done}, 1);
      chk(pcount == 1, "R9 permit pulses after first run", pcount, 1);
      chk(recov_cnt == 0, "R8 no recovery yet", recov_cnt, 0);
      chk(mem[8'h40] == 8'hA5, "R3 watched register loaded", mem[8'h40], 8'hA5);

      // R7: polling of watched register
      begin
         int r0;
         r0 = rcount;
         for (int i = 0; i < 200 && rcount < r0 + 2; i++) tick();
         chk(rcount >= r0 + 2, "R7 polls seen", rcount - r0, 2);
         chk(raddr == 8'h40, "R7 poll address", raddr, 8'h40);
         chk(rgap == P_POLL, "R7 poll spacing", rgap, P_POLL);
      end

      // R8: lost configuration triggers a re-run from the watchdog-disable write
      clear_log();
      mem[8'h40] = 8'h00;
      for (int i = 0; i < 100 && !busy; i++) tick();
      chk(busy && !done, "R8 restart after zero read", {busy, done}, 2);
      wait_done();
      check_table("R8 recovery run", 1);
      chk(recov_cnt == 1, "R8 recovery counted", recov_cnt, 1);
      chk(pcount == 1, "R9 no permit on recovery", pcount, 1);

      // R11: start while busy is ignored
      clear_log();
      do_start();
      repeat (5) tick();
      start = 1; tick(); start = 0;
      repeat (3) tick();
      start = 1; tick(); start = 0;
      wait_done();
      chk(wcount == NWR, "R11 single run despite extra starts", wcount, NWR);
      chk(wa[0] == 0 && wd[0] == 0, "R11 run began once", wd[0], 0);
      chk(pcount == 2, "R9 permit per start run", pcount, 2);

      // R12: slow target, values still in order
      clear_log();
      lat = 3;
      do_start();
      wait_done();
      check_table("R12 stalled target", 0);
      chk(error == 0, "R12 no error with slow target", error, 0);
      lat = 0;

      // R10: target never answers
      clear_log();
      dead = 1;
      do_start();
      for (int i = 0; i < 60 && busy; i++) tick();
      chk(error == 1, "R10 error on timeout", error, 1);
      chk({busy, done, bus_wr, bus_rd} == 4'b0000, "R10 parked after timeout",
          {busy, done, bus_wr, bus_rd}, 0);
      chk(wcount == 0, "R10 nothing accepted", wcount, 0);
      dead = 0;
      do_start();
      chk(error == 0, "R10 error cleared by start", error, 0);
      wait_done();
      chk(done == 1, "R10 completes after retry", done, 1);

      // R8: saturation over many recoveries
      lose = 1;
      mem[8'h40] = 8'h00;
      for (int i = 0; i < 60000 && recov_cnt != 8'hFF; i++) tick();
      begin
         int d0;
         d0 = drises;
         for (int i = 0; i < 2000 && drises < d0 + 3; i++) tick();
         chk(drises >= d0 + 3, "R8 recoveries continue", drises - d0, 3);
      end
      chk(recov_cnt == 8'hFF, "R8 counter saturates", recov_cnt, 8'hFF);
      chk(pcount == 4, "R9 permit count unchanged by recoveries", pcount, 4);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule